// File: doc/BRIEF.md
# Pulse-Width Field-Gap Write Sequencer

This block programs a low-frequency tag by keying the reader's field on and off. One start pulse captures a 64-bit data word and a 16-bit check field. The block then holds the field on to charge the tag and sends a fixed frame of fourteen bytes. Each bit is a field-off gap followed by a field-on interval, in a constant 2 ms bit slot. The gap width alone carries the bit value. After the last bit the field stays on while the tag programs itself. The block then releases the field and pulses done.

All durations are counted in clock cycles, derived from the `CLK_HZ` parameter with a resolution of 0.1 ms (one unit is `CLK_HZ/10000` cycles). The block does not compute the check field. The caller supplies it and the block sends it as given.

Top module: `pwgw_writer`

## Requirements
- R1: After reset, and whenever the block is not busy, `field_on_o` is 0, `busy_o` is 0 and `done_o` is 0. A synchronous reset during a frame returns the block to this idle state at once.
- R2: A start sampled on a rising clock edge while idle raises `busy_o` and `field_on_o` in the next cycle. The field then stays on for exactly 50 ms (500 units) as a charge phase.
- R3: A bit of value 1 is sent as the field off for 1.0 ms (10 units) followed by the field on for 1.0 ms (10 units).
- R4: A bit of value 0 is sent as the field off for 0.3 ms (3 units) followed by the field on for 1.7 ms (17 units).
- R5: The frame has 14 bytes sent in this order: 0xBB, 0xEB, data bytes `data_i[7:0]` up to `data_i[63:56]`, `chk_i[7:0]`, `chk_i[15:8]`, 0x00, 0x03.
- R6: Within every byte, bit 0 is sent first and bit 7 last.
- R7: After the on interval of the last bit, the field stays on for a further 50 ms (500 units) programming hold. The last bit is 0, so its on run lasts 517 units.
- R8: When the hold ends, `field_on_o` and `busy_o` fall in the same cycle and `done_o` is high for exactly that one cycle. The field then stays off until the next start.
- R9: A start pulse while busy is ignored, and the frame in progress continues unchanged.
- R10: Data and check inputs are captured when start is accepted. Later changes on them do not alter the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, frequency given by `CLK_HZ` |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled while idle |
| data_i | input | 64 | Data word to program |
| chk_i | input | 16 | Check field, sent verbatim |
| field_on_o | output | 1 | 1 = reader field on, 0 = field released |
| busy_o | output | 1 | High from accepted start until completion |
| done_o | output | 1 | One-cycle pulse when the frame is complete |

## Verification
A wrong bit index or wrong byte selection shows within one 2 ms slot, as a gap of the wrong width at some frame position. The bench measures every off run and every on run against the expected frame, so such a fault is reported at the first affected bit. A timer limit or phase transition that is wrong shows as a charge run, a hold run or a gap of the wrong length. A late or missing done shows in the cycle the field is released. A start that is not ignored while busy, or inputs that are not captured, would corrupt the gap sequence of the frame in flight.

// File: rtl/pwgw_pkg.sv
package pwgw_pkg;

    // Protocol durations in units of 0.1 ms
    localparam int unsigned UNITS_PER_S    = 10000;
    localparam int unsigned CHARGE_UNITS   = 500;
    localparam int unsigned HOLD_UNITS     = 500;
    localparam int unsigned SLOT_UNITS     = 20;
    localparam int unsigned GAP_ONE_UNITS  = 10;
    localparam int unsigned GAP_ZERO_UNITS = 3;

    // Frame layout
    localparam int unsigned FRAME_BYTES = 14;
    localparam int unsigned FRAME_BITS  = FRAME_BYTES * 8;
    localparam logic [7:0]  KEY_BYTE    = 8'hBB;
    localparam logic [7:0]  PASS_BYTE   = 8'hEB;
    localparam logic [7:0]  TAIL_LO     = 8'h00;
    localparam logic [7:0]  TAIL_HI     = 8'h03;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_CHARGE = 2'd1,
        PH_BITS   = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    typedef struct packed {
        logic [63:0] data;
        logic [15:0] chk;
    } payload_t;

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic [7:0] frame_byte(logic [3:0] idx, payload_t p);
        logic [7:0] b;
        case (idx)
            4'd0:    b = KEY_BYTE;
            4'd1:    b = PASS_BYTE;
            4'd2:    b = p.data[7:0];
            4'd3:    b = p.data[15:8];
            4'd4:    b = p.data[23:16];
            4'd5:    b = p.data[31:24];
            4'd6:    b = p.data[39:32];
            4'd7:    b = p.data[47:40];
            4'd8:    b = p.data[55:48];
            4'd9:    b = p.data[63:56];
            4'd10:   b = p.chk[7:0];
            4'd11:   b = p.chk[15:8];
            4'd12:   b = TAIL_LO;
            default: b = TAIL_HI;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/pwgw_bit_sel.sv
module pwgw_bit_sel
    import pwgw_pkg::*;
#(
    parameter int unsigned IDX_W = $clog2(FRAME_BITS)
) (
    input  payload_t           pay_i,
    input  logic [IDX_W-1:0]   bit_idx_i,
    output logic               bit_o
);
    logic [7:0] cur_byte;

    always_comb begin
        cur_byte = frame_byte(bit_idx_i[IDX_W-1:3], pay_i);
        bit_o    = cur_byte[bit_idx_i[2:0]];
    end
endmodule

// File: rtl/pwgw_timer.sv
module pwgw_timer #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_i,
    input  logic [CW-1:0] limit_i,
    output logic [CW-1:0] cnt_o,
    output logic          last_o
);
    always_ff @(posedge clk) begin
        if (rst || clr_i) cnt_o <= '0;
        else              cnt_o <= cnt_o + 1'b1;
    end

    assign last_o = (cnt_o == limit_i - 1'b1);
endmodule

// File: rtl/pwgw_writer.sv
module pwgw_writer
    import pwgw_pkg::*;
#(
    parameter int unsigned CLK_HZ = 24000000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [63:0] data_i,
    input  logic [15:0] chk_i,
    output logic        field_on_o,
    output logic        busy_o,
    output logic        done_o
);
    localparam int unsigned UNIT       = CLK_HZ / UNITS_PER_S;
    localparam int unsigned CHARGE_CYC = CHARGE_UNITS * UNIT;
    localparam int unsigned HOLD_CYC   = HOLD_UNITS * UNIT;
    localparam int unsigned SLOT_CYC   = SLOT_UNITS * UNIT;
    localparam int unsigned GAP1_CYC   = GAP_ONE_UNITS * UNIT;
    localparam int unsigned GAP0_CYC   = GAP_ZERO_UNITS * UNIT;
    localparam int unsigned CW         = $clog2(max3(CHARGE_CYC, HOLD_CYC, SLOT_CYC) + 1);
    localparam int unsigned IDX_W      = $clog2(FRAME_BITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    phase_e           phase_q;
    payload_t         pay_q;
    logic [IDX_W-1:0] bit_idx_q;
    logic             done_q;

    logic [CW-1:0]    cnt;
    logic [CW-1:0]    limit;
    logic             seg_last;
    logic             tmr_clr;
    logic             cur_bit;
    logic [CW-1:0]    gap_cyc;

    always_comb begin
        case (phase_q)
            PH_CHARGE: limit = CW'(CHARGE_CYC);
            PH_BITS:   limit = CW'(SLOT_CYC);
            PH_HOLD:   limit = CW'(HOLD_CYC);
            default:   limit = CW'(1);
        endcase
    end

    assign tmr_clr = (phase_q == PH_IDLE) || seg_last;

    pwgw_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (tmr_clr),
        .limit_i (limit),
        .cnt_o   (cnt),
        .last_o  (seg_last)
    );

    pwgw_bit_sel #(.IDX_W(IDX_W)) u_bit_sel (
        .pay_i     (pay_q),
        .bit_idx_i (bit_idx_q),
        .bit_o     (cur_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            pay_q     <= '0;
            bit_idx_q <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        pay_q     <= '{data: data_i, chk: chk_i};
                        bit_idx_q <= '0;
                        phase_q   <= PH_CHARGE;
                    end
                end
                PH_CHARGE: begin
                    if (seg_last) phase_q <= PH_BITS;
                end
                PH_BITS: begin
                    if (seg_last) begin
                        if (bit_idx_q == LAST_IDX) phase_q <= PH_HOLD;
                        else                       bit_idx_q <= bit_idx_q + 1'b1;
                    end
                end
                default: begin
                    if (seg_last) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign gap_cyc = cur_bit ? CW'(GAP1_CYC) : CW'(GAP0_CYC);

    always_comb begin
        case (phase_q)
            PH_CHARGE, PH_HOLD: field_on_o = 1'b1;
            PH_BITS:            field_on_o = (cnt >= gap_cyc);
            default:            field_on_o = 1'b0;
        endcase
    end

    assign busy_o = (phase_q != PH_IDLE);
    assign done_o = done_q;
endmodule

// File: rtl/pwgw_writer_chk.sv
module pwgw_writer_chk
    import pwgw_pkg::*;
#(
    parameter int unsigned CLK_HZ = 24000000
) (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic field_on_o,
    input logic busy_o,
    input logic done_o
);
    localparam int unsigned UNIT       = CLK_HZ / UNITS_PER_S;
    localparam int unsigned CHARGE_CYC = CHARGE_UNITS * UNIT;
    localparam int unsigned GAP1_CYC   = GAP_ONE_UNITS * UNIT;
    localparam int unsigned GAP0_CYC   = GAP_ZERO_UNITS * UNIT;

    logic [31:0] since_q;
    logic [31:0] low_q;

    always_ff @(posedge clk) begin
        if (rst || !busy_o)       since_q <= '0;
        else if (~&since_q)       since_q <= since_q + 1;
        if (rst || field_on_o)    low_q <= '0;
        else if (~&low_q)         low_q <= low_q + 1;
    end

    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !field_on_o);

    // R2
    charge_on_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && since_q < CHARGE_CYC) |-> field_on_o);

    // R2
    busy_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

    // R3 R4
    gap_width_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o) && $rose(field_on_o))
            |-> (low_q == GAP1_CYC || low_q == GAP0_CYC));

    // R8
    done_release_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o) && $past(field_on_o)));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
endmodule

bind pwgw_writer pwgw_writer_chk #(.CLK_HZ(CLK_HZ)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .field_on_o (field_on_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
);

// File: tb/pwgw_writer_tb.sv
module pwgw_writer_tb;
    localparam int unsigned CLK_HZ  = 20000;
    localparam int unsigned U       = CLK_HZ / 10000;
    localparam int unsigned NVEC    = 4;
    localparam int unsigned WD_CYC  = 150000;

    // {inject_start_while_busy, data, chk}
    localparam logic [80:0] VEC [NVEC] = '{
        {1'b0, 64'h0000_0000_0000_0000, 16'h0000},
        {1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 16'hFFFF},
        {1'b1, 64'h0123_4567_89AB_CDEF, 16'hBEEF},
        {1'b0, 64'h8000_0000_0000_0001, 16'h5A5A}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [63:0] data_i = '0;
    logic [15:0] chk_i = '0;
    logic        field_on_o, busy_o, done_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pwgw_writer #(.CLK_HZ(CLK_HZ)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .data_i(data_i), .chk_i(chk_i),
        .field_on_o(field_on_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(int k, logic [63:0] d, logic [15:0] c);
        if (k == 0)       return 8'hBB;
        else if (k == 1)  return 8'hEB;
        else if (k <= 9)  return d[8*(k-2) +: 8];
        else if (k == 10) return c[7:0];
        else if (k == 11) return c[15:8];
        else if (k == 12) return 8'h00;
        else              return 8'h03;
    endfunction

    task automatic check_idle(input string req);
        check(field_on_o == 1'b0, {req, " field"}, int'(field_on_o), 0);
        check(busy_o == 1'b0,     {req, " busy"},  int'(busy_o), 0);
        check(done_o == 1'b0,     {req, " done"},  int'(done_o), 0);
    endtask

    task automatic run_frame(input logic [63:0] d, input logic [15:0] c, input bit inject);
        int n;
        int lo;
        int hi;
        bit b;
        bit last;
        @(negedge clk);
        start_i = 1'b1; data_i = d; chk_i = c;
        @(negedge clk);
        start_i = 1'b0; data_i = ~d; chk_i = ~c;   // R10: inputs change after capture
        check(busy_o == 1'b1, "R2 busy after start", int'(busy_o), 1);
        n = 0;
        while (field_on_o && n < 100000) begin
            n++;
            if (inject && n == 50) begin start_i = 1'b1; data_i = 64'h0; chk_i = 16'h0; end
            if (inject && n == 51) start_i = 1'b0;   // R9: start while busy
            @(negedge clk);
        end
        check(n == int'(500*U), "R2 charge run", n, 500*U);
        for (int k = 0; k < 14; k++) begin
            for (int j = 0; j < 8; j++) begin
                b    = exp_byte(k, d, c)[j];
                last = (k == 13 && j == 7);
                lo = 0;
                while (!field_on_o && busy_o && lo < 100000) begin lo++; @(negedge clk); end
                hi = 0;
                while (field_on_o && hi < 100000) begin hi++; @(negedge clk); end
                // R5/R6 byte order and bit order select the expected bit; R9 R10 frame intact
                if (b) check(lo == int'(10*U), $sformatf("R3 gap at byte %0d bit %0d", k, j), lo, 10*U);
                else   check(lo == int'(3*U),  $sformatf("R4 gap at byte %0d bit %0d", k, j), lo, 3*U);
                if (last)
                    check(hi == int'((17+500)*U), "R7 last on run with hold", hi, (17+500)*U);
                else if (b)
                    check(hi == int'(10*U), $sformatf("R3 on at byte %0d bit %0d", k, j), hi, 10*U);
                else
                    check(hi == int'(17*U), $sformatf("R4 on at byte %0d bit %0d", k, j), hi, 17*U);
            end
        end
        check(busy_o == 1'b0, "R8 busy falls with field", int'(busy_o), 0);
        check(done_o == 1'b1, "R8 done at release", int'(done_o), 1);
        @(negedge clk);
        check(done_o == 1'b0, "R8 done one cycle", int'(done_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1 reset");
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1 idle after reset");

        for (int v = 0; v < int'(NVEC); v++)
            run_frame(VEC[v][79:16], VEC[v][15:0], VEC[v][80]);

        // R8: field stays released with no start
        repeat (20) @(negedge clk);
        check_idle("R8 stays idle");

        // R1: reset during a frame
        @(negedge clk); start_i = 1'b1; data_i = 64'h1; chk_i = 16'h1;
        @(negedge clk); start_i = 1'b0;
        repeat (100) @(negedge clk);
        check(busy_o == 1'b1, "R2 busy mid charge", int'(busy_o), 1);
        rst = 1'b1;
        @(negedge clk);
        check_idle("R1 reset mid frame");
        rst = 1'b0;

        // frame works after the aborted one
        run_frame(64'hA5A5_0F0F_3C3C_9696, 16'h1234, 1'b0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < int'(WD_CYC); i++) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", WD_CYC, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule